// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block follows the net position of a shaft that carries a two-channel quadrature encoder. The two channels, called C and D here, are square waves a quarter period apart. Both are sampled by the system clock through a short synchroniser chain, and a change between two successive synchronised samples counts as an edge. Which channel leads, and so which way the shaft turns, is learned by sampling the level of D whenever C rises. When D is already high at that moment the shaft is turning forward.

Every rising edge of either channel moves a binary position count by one step, in the direction currently held by the flag. The counter is fully synchronous. A bit flips only when every lower bit is 1 (counting up) or when every lower bit is 0 (counting down), and all bits update on the same clock edge, so no intermediate value is ever visible. A one-cycle strobe marks each cycle in which the count has just changed. The block is meant for motion tracking where the encoder signals are already clean; it does not filter contact bounce.

Top module: `qenc_position`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `position` to 0, sets `dirUp` to 1 and holds `countValid` at 0. Reset is synchronous and active high.
- R2: A rising edge on `encC` while `encD` is high sets `dirUp` to 1 and increments `position` by one. That same edge is counted in the new direction.
- R3: A rising edge on `encC` while `encD` is low clears `dirUp` to 0 and decrements `position` by one.
- R4: A rising edge on `encD` alone leaves `dirUp` unchanged and steps `position` by one. The step is +1 when `dirUp` is 1 and -1 when it is 0.
- R5: Falling edges on either channel have no effect. `position`, `dirUp` and `countValid` all stay unchanged.
- R6: `position` wraps modulo 2^COUNT_W. With the default of 4 bits, one step up from 15 gives 0 and one step down from 0 gives 15.
- R7: `countValid` is 1 for exactly the cycles in which `position` has just taken a new value. When both channels rise in the same sample, the block steps only once.
- R8: With the default of 2 synchroniser stages, take an input change that is first sampled at some rising edge. Its effect on `position`, `dirUp` and `countValid` appears after the third rising edge, counting that first edge as edge one.
- R9: Every change of `position` is exactly +1 or -1 (modulo 2^COUNT_W) in a single cycle, with no intermediate value. The sign of the change matches `dirUp` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| encC | input | 1 | Encoder channel C, asynchronous to clk; its rising edge samples the direction |
| encD | input | 1 | Encoder channel D, asynchronous to clk; its level gives the direction |
| position | output | COUNT_W | Net position count |
| dirUp | output | 1 | Current direction flag, 1 = counting up |
| countValid | output | 1 | One-cycle strobe, high when position has just changed |

## Verification
An input change driven between clock edges reaches `position`, `dirUp` and `countValid` three rising edges later: two synchroniser stages and then the counter register. The bench therefore samples at the falling edge after the second rising edge and expects no change yet. It samples again after the third rising edge and expects the new count, the new direction and a high strobe. One cycle later it expects the strobe to be low again. Inputs change only at falling edges, and only after the previous change has been fully checked. As a result, every expected value follows from a single arithmetic model of the count, the flag and the previous channel levels.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // Step request from the control module to the counter datapath
  typedef struct packed {
    logic step;  // advance the count this cycle
    logic up;    // direction of this step
  } stepCmd_t;

  localparam int CH_C = 0;
  localparam int CH_D = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int CHANNELS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] rawIn,
  output logic [CHANNELS-1:0] level,
  output logic [CHANNELS-1:0] rise
);
  localparam int LAST = STAGES - 1;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [STAGES-1:0] chain;
    logic              prevLevel;

    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= rawIn[ch];
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], rawIn[ch]};
      end
    end

    always_ff @(posedge clk) begin
      if (rst) prevLevel <= 1'b0;
      else     prevLevel <= chain[LAST];
    end

    assign level[ch] = chain[LAST];
    assign rise[ch]  = chain[LAST] & ~prevLevel;
  end
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] level,
  input  logic [NUM_CH-1:0] rise,
  output stepCmd_t          cmd,
  output logic              dirFlag
);
  logic stepDir;

  // A rising C edge takes the D level as the new direction at once
  assign stepDir  = rise[CH_C] ? level[CH_D] : dirFlag;
  assign cmd.up   = stepDir;
  assign cmd.step = rise[CH_C] | rise[CH_D];

  always_ff @(posedge clk) begin
    if (rst)             dirFlag <= 1'b1;
    else if (rise[CH_C]) dirFlag <= level[CH_D];
  end
endmodule

// File: rtl/qenc_count.sv
module qenc_count
  import qenc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  stepCmd_t         cmd,
  output logic [WIDTH-1:0] count,
  output logic             valid
);
  logic [WIDTH-1:0] onesBelow;
  logic [WIDTH-1:0] zerosBelow;
  logic [WIDTH-1:0] toggleMask;

  assign onesBelow[0]  = 1'b1;
  assign zerosBelow[0] = 1'b1;

  for (genvar i = 1; i < WIDTH; i++) begin : g_prefix
    assign onesBelow[i]  = onesBelow[i-1] & count[i-1];
    assign zerosBelow[i] = zerosBelow[i-1] & ~count[i-1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_toggle
    assign toggleMask[i] = cmd.up ? onesBelow[i] : zerosBelow[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      valid <= 1'b0;
    end else begin
      valid <= cmd.step;
      if (cmd.step) count <= count ^ toggleMask;
    end
  end
endmodule

// File: rtl/qenc_position.sv
module qenc_position
  import qenc_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               encC,
  input  logic               encD,
  output logic [COUNT_W-1:0] position,
  output logic               dirUp,
  output logic               countValid
);
  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] chLevel;
  logic [NUM_CH-1:0] chRise;
  stepCmd_t          stepCmd;

  assign rawIn[CH_C] = encC;
  assign rawIn[CH_D] = encD;

  qenc_sync #(.CHANNELS(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .rawIn(rawIn), .level(chLevel), .rise(chRise)
  );

  qenc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .level(chLevel), .rise(chRise),
    .cmd(stepCmd), .dirFlag(dirUp)
  );

  qenc_count #(.WIDTH(COUNT_W)) count_i (
    .clk(clk), .rst(rst), .cmd(stepCmd), .count(position), .valid(countValid)
  );
endmodule

// File: rtl/qenc_position_chk.sv
module qenc_position_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] position,
  input logic         dirUp,
  input logic         countValid
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R1: first cycle out of reset shows the reset state
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (position == '0 && dirUp && !countValid));

  // R7: any change of position is flagged by the strobe
  assert_change_strobed_R7: assert property (@(posedge clk) disable iff (rst)
    (position != $past(position)) |-> countValid);

  // R7: strobe only when position really changed
  assert_strobe_means_change_R7: assert property (@(posedge clk) disable iff (rst)
    countValid |-> (position != $past(position)));

  // R9, R2: an upward step is exactly +1
  assert_up_step_R9: assert property (@(posedge clk) disable iff (rst)
    (countValid && dirUp) |-> (position == $past(position) + ONE));

  // R9, R3: a downward step is exactly -1
  assert_down_step_R9: assert property (@(posedge clk) disable iff (rst)
    (countValid && !dirUp) |-> (position == $past(position) - ONE));
endmodule

bind qenc_position qenc_position_chk #(.W(COUNT_W)) chk_i (
  .clk(clk), .rst(rst), .position(position), .dirUp(dirUp), .countValid(countValid)
);

// File: tb/qenc_position_tb_top.sv
`timescale 1ns/1ps
module qenc_position_tb_top;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         encC = 1'b0;
  logic         encD = 1'b0;
  logic [W-1:0] position;
  logic         dirUp;
  logic         countValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int  expCount = 0;
  bit  expDir = 1'b1;
  bit  curC = 1'b0;
  bit  curD = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  qenc_position #(.COUNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .encC(encC), .encD(encD),
    .position(position), .dirUp(dirUp), .countValid(countValid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // Drive new channel levels at a falling edge and check R8 timing
  task automatic applyIn(input bit c, input bit d, input string req);
    bit cRise, dRise, stepNow;
    int oldCount;
    bit oldDir;
    cRise = c && !curC;
    dRise = d && !curD;
    oldCount = expCount;
    oldDir = expDir;
    if (cRise) expDir = d;
    stepNow = cRise || dRise;
    if (stepNow) expCount = expDir ? (expCount + 1) % MOD : (expCount + MOD - 1) % MOD;
    curC = c;
    curD = d;
    encC = c;
    encD = d;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8", "count before due", int'(position), oldCount);
    check("R8", "dir before due", int'(dirUp), int'(oldDir));
    check("R8", "strobe before due", int'(countValid), 0);
    @(posedge clk); @(negedge clk);
    check(req, "count", int'(position), expCount);
    check(req, "dir", int'(dirUp), int'(expDir));
    check("R7", "strobe", int'(countValid), int'(stepNow));
    @(posedge clk); @(negedge clk);
    check("R7", "strobe after one cycle", int'(countValid), 0);
    check(req, "count held", int'(position), expCount);
  endtask

  initial begin
    #(4 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "reset count", int'(position), 0);
    check("R1", "reset dir", int'(dirUp), 1);
    check("R1", "reset strobe", int'(countValid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "idle count", int'(position), 0);

    // R2 and R4: forward rotation, D leads C; 10 periods wrap past 15 (R6)
    for (int k = 0; k < 10; k++) begin
      applyIn(1'b0, 1'b1, "R4");
      applyIn(1'b1, 1'b1, "R2");
      applyIn(1'b1, 1'b0, "R5");
      applyIn(1'b0, 1'b0, "R5");
    end
    check("R6", "count after up wrap", int'(position), 4);

    // R3: reverse rotation, C leads D; wraps below 0 (R6)
    for (int k = 0; k < 12; k++) begin
      applyIn(1'b1, 1'b0, "R3");
      applyIn(1'b1, 1'b1, "R4");
      applyIn(1'b0, 1'b1, "R5");
      applyIn(1'b0, 1'b0, "R5");
    end
    check("R6", "count after down wrap", int'(position), 12);

    // R4 and R5: D toggling alone keeps counting down, falls ignored
    for (int k = 0; k < 3; k++) begin
      applyIn(1'b0, 1'b1, "R4");
      applyIn(1'b0, 1'b0, "R5");
    end

    // Near-exhaustive sweep over every pair of channel levels (R7 single step)
    for (int from = 0; from < 4; from++) begin
      for (int to = 0; to < 4; to++) begin
        applyIn(from[1], from[0], "R9");
        applyIn(to[1], to[0], "R9");
      end
    end

    // R1: reset mid-run clears state
    applyIn(1'b1, 1'b0, "R3");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "reset count again", int'(position), 0);
    check("R1", "reset dir again", int'(dirUp), 1);
    finishRun();
  end
endmodule